// File: doc/BRIEF.md
# Single-Frame Receive Buffer with Byte-Pop Register

This block sits between a network receive path and a host processor. A frame arrives on a byte stream: the first beat carries the frame length together with byte 0, and the later beats carry the remaining bytes in order. The block stores the frame only when its buffer is empty and the frame fits. When the last byte is stored, it loads a byte counter and sends a one-cycle receive-done pulse to an external interrupt controller.

The host drains the frame through a small register window. One register returns the number of unread bytes. A second register hands out the next byte on every read and decrements the counter. When the counter reaches zero, the buffer reopens, and the ready output tells the network side that another frame may be sent. A frame that cannot be taken is discarded and leaves no trace.

Top module: `rxfb_top`

## Requirements
- R1: After reset the unread count is 0, `rx_ready` is 1, `rx_done` is 0 and `bus_rdata` is 0.
- R2: A frame of length L, with 1 <= L <= 1513, that starts while the buffer is empty is stored. In the cycle after its last byte is taken, `rx_done` is high for exactly one cycle and the count register reads L.
- R3: A frame whose declared length is 1514 or more is dropped: no `rx_done`, the count stays 0 and `rx_ready` stays 1.
- R4: A frame whose declared length is 0 is dropped with no state change.
- R5: A frame that starts while unread bytes remain is dropped. The unread bytes and the count are unchanged.
- R6: Each read of the data register (byte offset 0x1C) returns the next stored byte in bits 7:0, zero-extended, starting at index 0. It also lowers the count by one.
- R7: A data register read when the count is 0 returns 0 and changes neither the count nor the read position.
- R8: `rx_ready` is 1 exactly when the count is 0 and no frame is being stored. It goes low while a frame is filling and rises again once the last byte has been read.
- R9: Accepting a new frame restarts the read position at index 0.
- R10: Bus writes to the count or data register change neither the count nor the stored bytes.
- R11: Reads return data on `bus_rdata` in the cycle after the read request. The count register sits at byte offset 0x0C, and any other offset reads 0.
- R12: A frame of exactly 1513 bytes is accepted, and every byte reads back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Receive byte beat valid |
| rx_first | input | 1 | Beat is the first byte of a frame; `rx_len` is valid |
| rx_len | input | 16 | Frame length in bytes, sampled on the first beat |
| rx_byte | input | 8 | Frame byte |
| rx_ready | output | 1 | Buffer empty and idle; a new frame will be taken |
| rx_done | output | 1 | One-cycle pulse when a frame has been stored |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Access is a write (1) or read (0) |
| bus_addr | input | 8 | Byte offset of the access |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |

## Verification
The embedded properties check, on every cycle, the things that can be seen locally. The count moves only by a load or a single-step pop. A load happens only into an empty buffer. The done pulse never lasts two cycles. Buffer write addresses stay in range, and the fill index never passes the declared length. Whether the bytes come back in the order they went in, how the drop rules apply, how the read position restarts for a new frame, and whether bus writes are harmless can only be shown by the directed scenarios. Those scenarios compare actual data against an independently computed byte pattern.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  localparam int unsigned RXFB_MAX_BYTES = 1514;
  localparam logic [7:0]  RXFB_OFF_COUNT = 8'h0C;
  localparam logic [7:0]  RXFB_OFF_DATA  = 8'h1C;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_COUNT = 2'd1,
    RK_DATA  = 2'd2
  } rkind_e;
endpackage

// File: rtl/rxfb_ingress.sv
module rxfb_ingress #(
  parameter int unsigned MAX_BYTES = 1514,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned IDX_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_first,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [7:0]       rx_byte,
  input  logic             buf_empty,
  output logic             filling,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [7:0]       wr_byte,
  output logic             load,
  output logic [IDX_W-1:0] load_len,
  output logic             done
);
  logic             fill_q, fill_d;
  logic [IDX_W-1:0] len_q, len_d;
  logic [IDX_W-1:0] widx_q, widx_d;
  logic             done_q, done_d;
  logic             fits, start_ok, beat, last;

  always_comb begin
    fits     = (rx_len != '0) && (rx_len < LEN_W'(MAX_BYTES));
    start_ok = rx_valid && rx_first && !fill_q && buf_empty && fits;
    beat     = rx_valid && !rx_first && fill_q;
    last     = (start_ok && (rx_len == LEN_W'(1))) ||
               (beat && (widx_q == len_q - IDX_W'(1)));
    wr_en    = start_ok || beat;
    wr_addr  = start_ok ? '0 : widx_q;
    wr_byte  = rx_byte;
    load     = last;
    load_len = start_ok ? rx_len[IDX_W-1:0] : len_q;

    fill_d = fill_q;
    len_d  = len_q;
    widx_d = widx_q;
    done_d = last;
    if (start_ok && !last) begin
      fill_d = 1'b1;
      len_d  = rx_len[IDX_W-1:0];
      widx_d = IDX_W'(1);
    end else if (beat) begin
      if (last) fill_d = 1'b0;
      else      widx_d = widx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= 1'b0;
      len_q  <= '0;
      widx_q <= '0;
      done_q <= 1'b0;
    end else begin
      fill_q <= fill_d;
      len_q  <= len_d;
      widx_q <= widx_d;
      done_q <= done_d;
    end
  end

  assign filling = fill_q;
  assign done    = done_q;

  // R2: receive-done is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R12: fill position never passes the declared length
  p_fill_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q |-> (widx_q < len_q));
endmodule

// File: rtl/rxfb_store.sv
module rxfb_store #(
  parameter int unsigned MAX_BYTES = 1514,
  parameter int unsigned IDX_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [7:0]       wr_byte,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_byte
);
  logic [7:0] mem_q [MAX_BYTES];
  logic [7:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(MAX_BYTES); i++) mem_q[i] <= 8'h00;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= 8'h00;
    else if (rd_en) rd_q <= mem_q[rd_addr];
  end

  assign rd_byte = rd_q;

  // R12: buffer accesses stay inside the array
  p_wr_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < IDX_W'(MAX_BYTES)));
  p_rd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < IDX_W'(MAX_BYTES)));
endmodule

// File: rtl/rxfb_host.sv
module rxfb_host
  import rxfb_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 1514,
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              load,
  input  logic [IDX_W-1:0]  load_len,
  input  logic              filling,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [7:0]        rd_byte,
  output logic              buf_empty,
  output logic              ready
);
  logic [IDX_W-1:0] count_q, count_d;
  logic [IDX_W-1:0] ridx_q, ridx_d;
  logic [IDX_W-1:0] snap_q, snap_d;
  rkind_e           kind_q, kind_d;
  logic             rd_hit, hit_data, hit_count, pop;

  always_comb begin
    rd_hit    = bus_sel && !bus_wr;
    hit_data  = rd_hit && (bus_addr == ADDR_W'(RXFB_OFF_DATA));
    hit_count = rd_hit && (bus_addr == ADDR_W'(RXFB_OFF_COUNT));
    pop       = hit_data && (count_q != '0);

    count_d = count_q;
    ridx_d  = ridx_q;
    if (load) begin
      count_d = load_len;
      ridx_d  = '0;
    end else if (pop) begin
      count_d = count_q - IDX_W'(1);
      ridx_d  = ridx_q + IDX_W'(1);
    end

    kind_d = kind_q;
    snap_d = snap_q;
    if (rd_hit) begin
      if (pop)            kind_d = RK_DATA;
      else if (hit_count) kind_d = RK_COUNT;
      else                kind_d = RK_NONE;
      snap_d = count_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ridx_q  <= '0;
      snap_q  <= '0;
      kind_q  <= RK_NONE;
    end else begin
      count_q <= count_d;
      ridx_q  <= ridx_d;
      snap_q  <= snap_d;
      kind_q  <= kind_d;
    end
  end

  always_comb begin
    unique case (kind_q)
      RK_DATA:  bus_rdata = DATA_W'(rd_byte);
      RK_COUNT: bus_rdata = DATA_W'(snap_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign rd_en     = pop;
  assign rd_addr   = ridx_q;
  assign buf_empty = (count_q == '0);
  assign ready     = buf_empty && !filling;

  // R5: a frame is only ever loaded into an empty buffer
  p_load_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (count_q == '0));
  // R6: every pop lowers the count by exactly one
  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (count_q == $past(count_q) - IDX_W'(1)));
  // R10: without load or pop the count holds (writes have no effect)
  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !pop) |=> $stable(count_q));
  // R7: a data read on an empty buffer leaves the read position alone
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && (count_q == '0) && !load) |=> $stable(ridx_q));
  // R3: the count never reaches the drop threshold
  p_count_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q < IDX_W'(MAX_BYTES));
endmodule

// File: rtl/rxfb_top.sv
module rxfb_top
  import rxfb_pkg::*;
#(
  parameter int unsigned MAX_BYTES = RXFB_MAX_BYTES,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              rx_done,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned IDX_W = $clog2(MAX_BYTES);

  logic             rst_meta_q, rst_sync_q;
  logic             filling, buf_empty;
  logic             wr_en, load, rd_en;
  logic [IDX_W-1:0] wr_addr, load_len, rd_addr;
  logic [7:0]       wr_byte, rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rxfb_ingress #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ingress (
    .clk(clk), .rst_n(rst_sync_q),
    .rx_valid(rx_valid), .rx_first(rx_first), .rx_len(rx_len), .rx_byte(rx_byte),
    .buf_empty(buf_empty), .filling(filling),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .load(load), .load_len(load_len), .done(rx_done)
  );

  rxfb_store #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_sync_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  rxfb_host #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_sync_q),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .load(load), .load_len(load_len), .filling(filling),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_byte(rd_byte),
    .buf_empty(buf_empty), .ready(rx_ready)
  );
endmodule

// File: tb/rxfb_top_tb_top.sv
module rxfb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CNT  = 8'h0C;
  localparam logic [7:0] A_DATA = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_first = 1'b0;
  logic [15:0] rx_len = '0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, rx_done;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxfb_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_first(rx_first), .rx_len(rx_len), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .rx_done(rx_done),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 7 + (i >> 8)) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic bus_write(input logic [7:0] a);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic send_frame(input int len, input int seed, input int beats,
                            output bit done_at, output bit done_late, output bit rdy_mid);
    rdy_mid = 1'b1;
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      if (i == 1) rdy_mid = rx_ready;
      rx_valid = 1'b1; rx_first = (i == 0); rx_len = 16'(len); rx_byte = pat(seed, i);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0;
    done_at = rx_done;
    @(negedge clk);
    done_late = rx_done;
  endtask

  task automatic read_count(input string req, input int exp);
    logic [31:0] d;
    bus_read(A_CNT, d);
    chk(d == 32'(exp), req, d, exp);
  endtask

  task automatic drain_check(input string req, input int seed, input int from, input int n);
    logic [31:0] d;
    int bad = 0;
    int first_bad_act = 0;
    int first_bad_exp = 0;
    for (int i = 0; i < n; i++) begin
      bus_read(A_DATA, d);
      if (d != {24'h0, pat(seed, from + i)}) begin
        if (bad == 0) begin first_bad_act = int'(d); first_bad_exp = int'(pat(seed, from + i)); end
        bad++;
      end
    end
    chk(bad == 0, req, first_bad_act, first_bad_exp);
  endtask

  task automatic t_reset();
    chk(rx_ready == 1'b1, "R1 ready", rx_ready, 1);
    chk(rx_done == 1'b0, "R1 done", rx_done, 0);
    chk(bus_rdata == 32'h0, "R1 rdata", bus_rdata, 0);
    read_count("R1 count", 0);
  endtask

  task automatic t_basic();
    bit da, dl, rm;
    logic [31:0] d;
    send_frame(5, 3, 5, da, dl, rm);
    chk(da == 1'b1, "R2 done pulse", da, 1);
    chk(dl == 1'b0, "R2 done one cycle", dl, 0);
    chk(rm == 1'b0, "R8 ready low while filling", rm, 0);
    chk(rx_ready == 1'b0, "R8 ready low when loaded", rx_ready, 0);
    read_count("R2 count", 5);
    bus_read(A_DATA, d);
    chk(d == {24'h0, pat(3, 0)}, "R6 first byte", d, pat(3, 0));
    read_count("R6 count decrement", 4);
    drain_check("R6 byte order", 3, 1, 4);
    read_count("R6 count zero", 0);
    chk(rx_ready == 1'b1, "R8 ready after drain", rx_ready, 1);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    bus_read(A_DATA, d);
    chk(d == 32'h0, "R7 empty read data", d, 0);
    read_count("R7 count unchanged", 0);
  endtask

  task automatic t_drop(input int len, input string req);
    bit da, dl, rm;
    send_frame(len, 21, 12, da, dl, rm);
    chk(da == 1'b0 && dl == 1'b0, req, da, 0);
    chk(rx_ready == 1'b1, req, rx_ready, 1);
    read_count(req, 0);
  endtask

  task automatic t_busy_and_reindex();
    bit da, dl, rm;
    logic [31:0] d;
    send_frame(4, 10, 4, da, dl, rm);
    bus_read(A_DATA, d);
    chk(d == {24'h0, pat(10, 0)}, "R6 frame A byte0", d, pat(10, 0));
    send_frame(3, 99, 3, da, dl, rm);
    chk(da == 1'b0, "R5 busy drop no done", da, 0);
    read_count("R5 count kept", 3);
    bus_write(A_CNT);
    bus_write(A_DATA);
    read_count("R10 count after writes", 3);
    drain_check("R10 R5 bytes intact", 10, 1, 3);
    send_frame(2, 50, 2, da, dl, rm);
    chk(da == 1'b1, "R9 new frame done", da, 1);
    drain_check("R9 read restarts at 0", 50, 0, 2);
  endtask

  task automatic t_other_addr();
    bit da, dl, rm;
    logic [31:0] d;
    send_frame(1, 7, 1, da, dl, rm);
    chk(da == 1'b1, "R2 single byte frame", da, 1);
    bus_read(8'h10, d);
    chk(d == 32'h0, "R11 other offset", d, 0);
    bus_read(8'h00, d);
    chk(d == 32'h0, "R11 offset zero", d, 0);
    read_count("R11 count offset", 1);
    drain_check("R11 data offset", 7, 0, 1);
  endtask

  task automatic t_max();
    bit da, dl, rm;
    send_frame(1513, 44, 1513, da, dl, rm);
    chk(da == 1'b1, "R12 max frame done", da, 1);
    read_count("R12 max count", 1513);
    drain_check("R12 max bytes", 44, 0, 1513);
    read_count("R12 drained", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_empty_read();
    t_drop(1514, "R3 oversize 1514");
    t_drop(3000, "R3 oversize 3000");
    t_drop(0, "R4 zero length");
    t_busy_and_reindex();
    t_other_addr();
    t_max();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule